// File: doc/BRIEF.md
# Slave-FIFO Video Test-Pattern Streamer

This block lives in an FPGA next to a USB bridge chip and acts as the master of the bridge's synchronous slave-FIFO write port. Once the bridge raises a start request, the block sends uncompressed YUY2 video frames (two bytes per pixel, one pixel per 16-bit word) into the bridge buffer. It obeys a ready flag for flow control and closes each frame with a one-cycle packet-end strobe, which commits any short packet left at the tail.

The pixel source is fixed at build time. It is either a set of eight vertical colour bars or an incrementing 16-bit ramp. A one-cycle frame-sync pulse marks the first word of every frame. Frame geometry defaults to 640x480. It is a parameter so that a small configuration can be swept completely.

Top module: `vfs_streamer`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `wrStrobe`, `pktEnd` and `frameSync` are all low.
- R2: In the idle state no write is made. The block leaves idle at a rising clock edge where `startReq` is high, and it can write from the next cycle on.
- R3: `wrStrobe` is high only in cycles where `fifoRdy` is high. While a frame is in progress, every cycle with `fifoRdy` high is a write.
- R4: While a write is held back by `fifoRdy` low, `dataOut` keeps the word that is waiting to be written.
- R5: `frameSync` is high exactly in the cycle that writes word 0 of a frame, and in no other cycle.
- R6: A frame is `H_PIXELS*V_LINES` writes. In the cycle after the last write, `pktEnd` is high for one cycle with no write. `pktEnd` is low at all other times.
- R7: After the `pktEnd` cycle the block spends one cycle idle, where it samples `startReq` as in R2. If `startReq` is dropped during a frame, the frame still completes, and no further frame starts.
- R8: Bar mode (`PATTERN`=0). Word k of a frame has column x = k mod `H_PIXELS` and bar b = (x / (`H_PIXELS`/`NUM_BARS`)) mod 8. Bits [7:0] carry Y. Bits [15:8] carry Cb when x is even and Cr when x is odd. Bars 0..7 have (Y,Cb,Cr) = (180,128,128), (162,44,142), (131,156,44), (112,72,58), (84,184,198), (65,100,212), (35,212,114), (16,128,128).
- R9: Ramp mode (`PATTERN`=1). Word k of a frame is k modulo 65536. The ramp restarts at 0 at every frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock shared with the bridge |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Stream request from the bridge GPIO |
| fifoRdy | input | 1 | High when the bridge buffer can take a word |
| wrStrobe | output | 1 | Write strobe, active high |
| pktEnd | output | 1 | Packet-end strobe, active high |
| frameSync | output | 1 | High on the first word of each frame |
| dataOut | output | 16 | Pixel word: Y in the low byte, chroma in the high byte |

## Verification
The hardest cases to reach are at frame edges. One is a stall that falls on the last word of a frame or on word 0. Another is dropping `startReq` partway through a frame, which must still end with `pktEnd` and then stop. The bench uses a 16x4 frame, so every word position recurs many times within a short run. It drives `fifoRdy` from an LFSR in random and long-stall modes, so stalls land on every position, including the frame boundaries. It also drops `startReq` at a random point and later raises it again. A bench-side model of the frame position and of the idle, stream and commit phases, built from the requirements, predicts every output in every cycle for two instances at once: one in bar mode and one in ramp mode.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STREAM = 2'd1,
    ST_COMMIT = 2'd2
  } strmState_t;

  typedef struct packed {
    logic frameClr;
    logic advance;
  } dpCtrl_t;

  localparam int PAT_BARS = 0;
  localparam int PAT_RAMP = 1;

  // returns {Y, Cb, Cr}
  function automatic logic [23:0] barColour(input logic [2:0] idx);
    logic [23:0] c;
    case (idx)
      3'd0: c = {8'd180, 8'd128, 8'd128};
      3'd1: c = {8'd162, 8'd44,  8'd142};
      3'd2: c = {8'd131, 8'd156, 8'd44 };
      3'd3: c = {8'd112, 8'd72,  8'd58 };
      3'd4: c = {8'd84,  8'd184, 8'd198};
      3'd5: c = {8'd65,  8'd100, 8'd212};
      3'd6: c = {8'd35,  8'd212, 8'd114};
      default: c = {8'd16, 8'd128, 8'd128};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/vfs_datapath.sv
module vfs_datapath
  import vfs_pkg::*;
#(
  parameter int H_PIXELS = 640,
  parameter int V_LINES  = 480,
  parameter int NUM_BARS = 8,
  parameter int PATTERN  = PAT_BARS
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpCtrl_t     ctl,
  output logic        firstWord,
  output logic        lastWord,
  output logic [15:0] word
);
  localparam int COL_W = (H_PIXELS > 1) ? $clog2(H_PIXELS) : 1;
  localparam int ROW_W = (V_LINES > 1) ? $clog2(V_LINES) : 1;
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(H_PIXELS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(V_LINES - 1);

  logic [COL_W-1:0] colCnt;
  logic [ROW_W-1:0] rowCnt;
  logic             endOfLine;

  assign endOfLine = (colCnt == COL_LAST);
  assign lastWord  = endOfLine && (rowCnt == ROW_LAST);
  assign firstWord = (colCnt == '0) && (rowCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.frameClr) begin
      colCnt <= '0;
      rowCnt <= '0;
    end else if (ctl.advance) begin
      if (endOfLine) begin
        colCnt <= '0;
        rowCnt <= (rowCnt == ROW_LAST) ? '0 : rowCnt + 1'b1;
      end else begin
        colCnt <= colCnt + 1'b1;
      end
    end
  end

  generate
    if (PATTERN == PAT_RAMP) begin : g_ramp
      logic [15:0] rampCnt;
      always_ff @(posedge clk) begin
        if (!rstN || ctl.frameClr) rampCnt <= '0;
        else if (ctl.advance)      rampCnt <= rampCnt + 16'd1;
      end
      assign word = rampCnt;
    end else begin : g_bars
      localparam int BAR_PIX = (H_PIXELS / NUM_BARS > 0) ? H_PIXELS / NUM_BARS : 1;
      localparam int BP_W    = (BAR_PIX > 1) ? $clog2(BAR_PIX) : 1;
      localparam logic [BP_W-1:0] BP_LAST = BP_W'(BAR_PIX - 1);

      logic [BP_W-1:0] barPix;
      logic [2:0]      barIdx;
      logic [23:0]     colour;

      always_ff @(posedge clk) begin
        if (!rstN || ctl.frameClr) begin
          barPix <= '0;
          barIdx <= '0;
        end else if (ctl.advance) begin
          if (endOfLine) begin
            barPix <= '0;
            barIdx <= '0;
          end else if (barPix == BP_LAST) begin
            barPix <= '0;
            barIdx <= barIdx + 3'd1;
          end else begin
            barPix <= barPix + 1'b1;
          end
        end
      end

      assign colour = barColour(barIdx);
      assign word   = {colCnt[0] ? colour[7:0] : colour[15:8], colour[23:16]};
    end
  endgenerate

endmodule

// File: rtl/vfs_ctrl.sv
module vfs_ctrl
  import vfs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    fifoRdy,
  input  logic    firstWord,
  input  logic    lastWord,
  output dpCtrl_t ctl,
  output logic    streamOn,
  output logic    wrStrobe,
  output logic    pktEnd,
  output logic    frameSync
);
  strmState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE:   if (startReq) stateNxt = ST_STREAM;
      ST_STREAM: if (fifoRdy && lastWord) stateNxt = ST_COMMIT;
      ST_COMMIT: stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  assign streamOn     = (state == ST_STREAM);
  assign wrStrobe     = streamOn && fifoRdy;
  assign pktEnd       = (state == ST_COMMIT);
  assign frameSync    = wrStrobe && firstWord;
  assign ctl.frameClr = (state == ST_IDLE);
  assign ctl.advance  = wrStrobe;

endmodule

// File: rtl/vfs_streamer.sv
module vfs_streamer
  import vfs_pkg::*;
#(
  parameter int H_PIXELS = 640,
  parameter int V_LINES  = 480,
  parameter int NUM_BARS = 8,
  parameter int PATTERN  = PAT_BARS
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        fifoRdy,
  output logic        wrStrobe,
  output logic        pktEnd,
  output logic        frameSync,
  output logic [15:0] dataOut
);
  dpCtrl_t ctl;
  logic    firstWord;
  logic    lastWord;
  logic    streamOn;

  vfs_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .fifoRdy   (fifoRdy),
    .firstWord (firstWord),
    .lastWord  (lastWord),
    .ctl       (ctl),
    .streamOn  (streamOn),
    .wrStrobe  (wrStrobe),
    .pktEnd    (pktEnd),
    .frameSync (frameSync)
  );

  vfs_datapath #(
    .H_PIXELS (H_PIXELS),
    .V_LINES  (V_LINES),
    .NUM_BARS (NUM_BARS),
    .PATTERN  (PATTERN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .firstWord (firstWord),
    .lastWord  (lastWord),
    .word      (dataOut)
  );

endmodule

// File: rtl/vfs_checker.sv
module vfs_checker (
  input logic        clk,
  input logic        rstN,
  input logic        fifoRdy,
  input logic        streamOn,
  input logic        wrStrobe,
  input logic        pktEnd,
  input logic        frameSync,
  input logic [15:0] dataOut
);
  p_write_needs_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> fifoRdy);

  p_stall_holds_word_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(streamOn) && !$past(wrStrobe) && streamOn) |-> $stable(dataOut));

  p_sync_on_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |-> wrStrobe);

  p_sync_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> !frameSync);

  p_pkt_after_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    pktEnd |-> ($past(wrStrobe) && !wrStrobe));

  p_pkt_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    pktEnd |=> (!pktEnd && !wrStrobe));

endmodule

bind vfs_streamer vfs_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .fifoRdy   (fifoRdy),
  .streamOn  (streamOn),
  .wrStrobe  (wrStrobe),
  .pktEnd    (pktEnd),
  .frameSync (frameSync),
  .dataOut   (dataOut)
);

// File: tb/sim_vfs_streamer.sv
`timescale 1ns/1ps
module sim_vfs_streamer;
  localparam int H = 16;
  localparam int V = 4;
  localparam int NB = 8;
  localparam int FRAME = H * V;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic fifoRdy = 1'b0;
  logic wrA, pktA, syncA, wrB, pktB, syncB;
  logic [15:0] dataA, dataB;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  vfs_streamer #(.H_PIXELS(H), .V_LINES(V), .NUM_BARS(NB), .PATTERN(0)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .fifoRdy(fifoRdy),
    .wrStrobe(wrA), .pktEnd(pktA), .frameSync(syncA), .dataOut(dataA));

  vfs_streamer #(.H_PIXELS(H), .V_LINES(V), .NUM_BARS(NB), .PATTERN(1)) u1 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .fifoRdy(fifoRdy),
    .wrStrobe(wrB), .pktEnd(pktB), .frameSync(syncB), .dataOut(dataB));

  // model: 0 idle, 1 stream, 2 commit
  int mState = 0;
  int k = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d (state %0d word %0d)", req, act, exp, mState, k);
    end
  endtask

  function automatic logic [15:0] barWord(input int idx);
    int x, b;
    int yv[8]  = '{180, 162, 131, 112, 84, 65, 35, 16};
    int cbv[8] = '{128, 44, 156, 72, 184, 100, 212, 128};
    int crv[8] = '{128, 142, 44, 58, 198, 212, 114, 128};
    x = idx % H;
    b = (x / (H / NB)) % 8;
    return {8'((x % 2) ? crv[b] : cbv[b]), 8'(yv[b])};
  endfunction

  task automatic step(input logic st, input logic rdy);
    bit expWr;
    @(negedge clk);
    startReq = st;
    fifoRdy  = rdy;
    #2;
    expWr = (mState == 1) && rdy;
    if (mState == 1) begin
      check(wrA == expWr, "R3 write strobe bars", int'(wrA), int'(expWr));
      check(wrB == expWr, "R3 write strobe ramp", int'(wrB), int'(expWr));
      check(dataA == barWord(k), rdy ? "R8 bar word" : "R4 R8 held bar word", int'(dataA), int'(barWord(k)));
      check(dataB == 16'(k), rdy ? "R9 ramp word" : "R4 R9 held ramp word", int'(dataB), k);
    end else begin
      check(wrA == 1'b0 && wrB == 1'b0, "R2 R7 no write outside frame", int'(wrA | wrB), 0);
    end
    check(syncA == (expWr && k == 0) && syncB == syncA, "R5 frame sync",
          int'(syncA), int'(expWr && k == 0));
    check(pktA == (mState == 2) && pktB == pktA, "R6 packet end", int'(pktA), int'(mState == 2));
    // advance model at the coming edge
    case (mState)
      0: if (st) begin mState = 1; k = 0; end
      1: if (expWr) begin
           if (k == FRAME - 1) mState = 2;
           else k++;
         end
      default: begin mState = 0; k = 0; end
    endcase
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int stopAt;
    repeat (3) @(negedge clk);
    check(wrA == 0 && pktA == 0 && syncA == 0 && wrB == 0 && pktB == 0 && syncB == 0,
          "R1 outputs in reset", int'({wrA, pktA, syncA}), 0);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    check(wrA == 0 && pktA == 0 && syncA == 0, "R1 outputs after reset", int'({wrA, pktA, syncA}), 0);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1);        // R2: idle with ready high
    for (int i = 0; i < 220; i++) step(1'b1, 1'b1);       // back-to-back frames
    for (int i = 0; i < 600; i++) step(1'b1, lfsr[0] | lfsr[5]);
    for (int i = 0; i < 600; i++) step(1'b1, (i % 13) > 9 || lfsr[3]);
    stopAt = 20 + int'(lfsr[4:0]);
    for (int i = 0; i < stopAt; i++) step(1'b1, lfsr[1] | lfsr[7]);
    for (int i = 0; i < 400; i++) step(1'b0, lfsr[2] | lfsr[9]);  // R7 stop at boundary
    check(mState == 0, "R7 stream stopped", mState, 0);
    for (int i = 0; i < 200; i++) step(1'b1, lfsr[0] | lfsr[6]);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule